// File: doc/BRIEF.md
# Plotter command and mode encoder

This block sits between the host register interface and a raster plotter's parallel output path. Each 4-bit command write is decoded into one of two actions. Codes `00xx` fire one of four remote command lines (line terminate, end of transmission, form feed, clear) for a fixed number of clock cycles. Codes `1x SP PL` queue a mode change, either normal print, plot, or simultaneous print/plot. Codes `01xx` are reserved and do nothing.

A mode change does not take effect when it is written. It goes into the same queue as the data bytes, as a tagged entry. When that entry reaches the head of the queue it is removed without a device data strobe, and the output mode is updated. Bytes written before the mode change therefore leave under the old mode, and bytes written after it leave under the new one. The mode bits have their own output, which also serves as the status value.

Bit 2 of a mode write chooses whether the write also clears the device-ready synchronising flip-flop. That flip-flop is set in two ways: by a true-false-true sequence on the device ready input, or by a software acknowledge strobe.

The command pulse machine has two states, `P_IDLE` and `P_ACTIVE`:
- `P_IDLE` goes to `P_ACTIVE` on *fire*, which is a `00xx` write.
- `P_ACTIVE` goes back to `P_IDLE` on *expire*, when the counter reaches zero, or on *abort*, which is master clear.

The ready sequencer has three states, `S_AWAIT_HIGH`, `S_AWAIT_LOW` and `S_AWAIT_RISE`:
- `S_AWAIT_HIGH` goes to `S_AWAIT_LOW` on *first_true*.
- `S_AWAIT_LOW` goes to `S_AWAIT_RISE` on *went_false*.
- `S_AWAIT_RISE` goes to `S_AWAIT_LOW` on *seq_hit*, which sets the flip-flop.
- Master clear returns the sequencer to `S_AWAIT_HIGH` from any state.

Top module: `plot_cmd_encoder`

## Requirements
- R1: After reset, `pulse_o`, `out_valid`, `q_full` and `rdy_ff` are all 0, and `out_mode` is 2'b00 (normal print).
- R2: A write with `cmd_code` 00xx drives `pulse_o[cmd_code[1:0]]` high for exactly PULSE_CYC cycles, starting at the edge that captures the write. The bit meanings are: bit0 line terminate, bit1 end of transmission, bit2 form feed, bit3 clear. The other bits stay low.
- R3: A 00xx write that arrives while a pulse is active is ignored. After the pulse ends, a new command is accepted.
- R4: Codes 01xx have no effect. They produce no pulse, no queue entry, no mode change and no change to `rdy_ff`.
- R5: A write with code {1, K, SP, PL} queues a mode entry. `out_mode` = {SP, PL} (bit1 simultaneous print/plot, bit0 plot) changes only when that entry reaches the queue head. Bytes queued before the entry leave with the previous mode.
- R6: A mode entry at the head is removed without `out_take`, and `out_valid` stays low for it.
- R7: A mode write with K=0 (10xx) clears `rdy_ff`. A mode write with K=1 (11xx) leaves `rdy_ff` unchanged.
- R8: `rdy_ff` is set by `dev_rdy` going high, then low, then high, or by a one-cycle `sw_ack`. A clear in the same cycle wins over a set.
- R9: When the queue holds DEPTH entries, `q_full` is 1 and further writes are dropped. A `data_wr` in the same cycle as a mode write is dropped.
- R10: `mclr` empties the queue, stops any pulse, clears `rdy_ff` and restarts the ready sequence. It leaves `out_mode` unchanged.
- R11: Data bytes leave in write order, one per cycle where `out_valid` and `out_take` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mclr | input | 1 | Master clear strobe |
| cmd_wr | input | 1 | Command/mode write strobe |
| cmd_code | input | 4 | Command/mode code |
| data_wr | input | 1 | Data byte write strobe |
| data_in | input | DATA_W | Data byte |
| q_full | output | 1 | Queue full |
| out_valid | output | 1 | Data byte present at queue head |
| out_data | output | DATA_W | Head data byte |
| out_take | input | 1 | Device takes head byte |
| out_mode | output | 2 | Mode in force at output {SP, PL} |
| pulse_o | output | 4 | Remote command lines |
| dev_rdy | input | 1 | Device ready input |
| sw_ack | input | 1 | Software acknowledge strobe |
| rdy_ff | output | 1 | Ready synchronising flip-flop |

## Verification
The bench blocks the output while bytes and a mode change are queued. It then checks that `out_mode` still shows the old value. A design that applied the mode at write time would switch too early, and the scoreboard would also see bytes tagged with the wrong mode.

A second command is fired in the middle of a pulse. A design that restarted or re-targeted the pulse would show the clear line, or too many cycles on the first line.

Other cases covered are:
- A partial true-false sequence on `dev_rdy`, which must not set `rdy_ff`.
- A clear and an acknowledge in the same cycle, where the clear must win.
- Reserved codes, which must leave every output and `rdy_ff` unchanged.
- A full queue, which must drop writes.
- Master clear, which must keep the output mode.

// File: rtl/plot_enc_pkg.sv
package plot_enc_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              is_mode;
        logic [DATA_W-1:0] payload;
    } q_entry_t;

    typedef enum logic { P_IDLE, P_ACTIVE } pulse_state_t;

    typedef enum logic [1:0] {
        S_AWAIT_HIGH,
        S_AWAIT_LOW,
        S_AWAIT_RISE
    } seq_state_t;

    localparam logic [1:0] GRP_PULSE    = 2'b00;
    localparam logic [1:0] GRP_RESERVED = 2'b01;
endpackage

// File: rtl/pulse_gen.sv
module pulse_gen
    import plot_enc_pkg::*;
#(
    parameter int PULSE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       fire,
    input  logic [1:0] sel_in,
    output logic [3:0] pulse_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    pulse_state_t    state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [1:0]      sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE:   if (fire) state_d = P_ACTIVE;
            P_ACTIVE: if (cnt_q == '0) state_d = P_IDLE;
            default:  state_d = P_IDLE;
        endcase
        if (abort) state_d = P_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == P_IDLE && fire) begin
                cnt_q <= CW'(PULSE_CYC - 1);
                sel_q <= sel_in;
            end else if (state_q == P_ACTIVE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        pulse_o = '0;
        if (state_q == P_ACTIVE) pulse_o[sel_q] = 1'b1;
    end

    assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_o));
    assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|pulse_o) |-> $past(fire));
endmodule

// File: rtl/ready_sync.sv
module ready_sync
    import plot_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic dev_rdy,
    input  logic sw_ack,
    input  logic clr,
    output logic rdy_ff
);
    seq_state_t state_q, state_d;
    logic       seq_hit;

    always_comb begin
        state_d = state_q;
        seq_hit = 1'b0;
        unique case (state_q)
            S_AWAIT_HIGH: if (dev_rdy)  state_d = S_AWAIT_LOW;
            S_AWAIT_LOW:  if (!dev_rdy) state_d = S_AWAIT_RISE;
            S_AWAIT_RISE: if (dev_rdy) begin
                state_d = S_AWAIT_LOW;
                seq_hit = 1'b1;
            end
            default: state_d = S_AWAIT_HIGH;
        endcase
        if (restart) state_d = S_AWAIT_HIGH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_AWAIT_HIGH;
            rdy_ff  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr || restart)          rdy_ff <= 1'b0;
            else if (seq_hit || sw_ack)  rdy_ff <= 1'b1;
        end
    end

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rdy_ff);
    assert_set_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_ff) |-> $past(dev_rdy || sw_ack));
endmodule

// File: rtl/tag_fifo.sv
module tag_fifo
    import plot_enc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     push,
    input  q_entry_t wdata,
    input  logic     pop,
    output q_entry_t head,
    output logic     empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_entry_t      mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp_q];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= nxt(wp_q);
            if (do_pop)  rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop && !flush |=> full);
endmodule

// File: rtl/plot_cmd_encoder.sv
module plot_cmd_encoder
    import plot_enc_pkg::*;
#(
    parameter int PULSE_CYC = 8,
    parameter int DEPTH     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              cmd_wr,
    input  logic [3:0]        cmd_code,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic              q_full,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_take,
    output logic [1:0]        out_mode,
    output logic [3:0]        pulse_o,
    input  logic              dev_rdy,
    input  logic              sw_ack,
    output logic              rdy_ff
);
    logic     is_pulse_cmd, is_mode_cmd, clr_ready;
    logic     push, pop, head_mode, empty;
    q_entry_t wentry, head;

    assign is_pulse_cmd = cmd_wr && (cmd_code[3:2] == GRP_PULSE);
    assign is_mode_cmd  = cmd_wr && cmd_code[3];
    assign clr_ready    = is_mode_cmd && !cmd_code[2];

    always_comb begin
        wentry = '0;
        if (is_mode_cmd) begin
            wentry.is_mode      = 1'b1;
            wentry.payload[1:0] = cmd_code[1:0];
        end else begin
            wentry.payload = data_in;
        end
    end

    assign push      = is_mode_cmd || data_wr;
    assign head_mode = !empty && head.is_mode;
    assign out_valid = !empty && !head.is_mode;
    assign out_data  = head.payload;
    assign pop       = head_mode || (out_valid && out_take);

    pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .abort(mclr),
        .fire(is_pulse_cmd), .sel_in(cmd_code[1:0]), .pulse_o(pulse_o)
    );

    ready_sync u_ready (
        .clk(clk), .rst_n(rst_n), .restart(mclr), .dev_rdy(dev_rdy),
        .sw_ack(sw_ack), .clr(clr_ready), .rdy_ff(rdy_ff)
    );

    tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(mclr), .push(push), .wdata(wentry),
        .pop(pop), .head(head), .empty(empty), .full(q_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  out_mode <= 2'b00;
        else if (head_mode && !mclr) out_mode <= head.payload[1:0];
    end

    assert_mode_moves_at_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_mode) |-> $past(head_mode));
    assert_mclr_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> $stable(out_mode));
endmodule

// File: tb/test_plot_cmd_encoder.sv
module test_plot_cmd_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, mclr = 1'b0, cmd_wr = 1'b0, data_wr = 1'b0;
    logic [3:0] cmd_code = '0;
    logic [7:0] data_in = '0;
    logic       out_take = 1'b0, dev_rdy = 1'b0, sw_ack = 1'b0;
    logic       q_full, out_valid, rdy_ff;
    logic [7:0] out_data;
    logic [1:0] out_mode;
    logic [3:0] pulse_o;

    int n_chk = 0, n_bad = 0;
    logic [9:0] exp_q[$];
    logic [1:0] cur_mode = 2'b00;
    int pcnt[4];
    bit done = 0;

    always #2 clk = ~clk;

    plot_cmd_encoder i_plot_cmd_encoder (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .data_wr(data_wr), .data_in(data_in), .q_full(q_full), .out_valid(out_valid),
        .out_data(out_data), .out_take(out_take), .out_mode(out_mode), .pulse_o(pulse_o),
        .dev_rdy(dev_rdy), .sw_ack(sw_ack), .rdy_ff(rdy_ff)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic issue(input logic [3:0] c);
        cmd_wr = 1'b1; cmd_code = c;
        step();
        cmd_wr = 1'b0;
        if (c[3]) cur_mode = c[1:0];
    endtask

    task automatic put_data(input logic [7:0] b, input bit kept);
        data_wr = 1'b1; data_in = b;
        step();
        data_wr = 1'b0;
        if (kept) exp_q.push_back({cur_mode, b});
    endtask

    task automatic clr_cnt();
        for (int b = 0; b < 4; b++) pcnt[b] = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < 4; b++) if (pulse_o[b]) pcnt[b]++;
            if (out_valid && out_take) begin
                if (exp_q.size() == 0) chk(0, "R11 unexpected byte", out_data, 0);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e[7:0], "R11 data order", out_data, e[7:0]);
                    chk(out_mode == e[9:8], "R5 mode with byte", out_mode, e[9:8]);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        chk(pulse_o == 0, "R1 pulse_o", pulse_o, 0);
        chk(!out_valid && !q_full, "R1 queue", {out_valid, q_full}, 0);
        chk(out_mode == 0, "R1 out_mode", out_mode, 0);
        chk(!rdy_ff, "R1 rdy_ff", rdy_ff, 0);

        // R2: each command line
        for (int c = 0; c < 4; c++) begin
            clr_cnt();
            issue(4'(c));
            repeat (12) step();
            for (int b = 0; b < 4; b++)
                chk(pcnt[b] == ((b == c) ? 8 : 0), "R2 pulse width/line", pcnt[b], (b == c) ? 8 : 0);
        end

        // R3: command during active pulse ignored
        clr_cnt();
        issue(4'b0000); step(); step();
        issue(4'b0011);
        repeat (12) step();
        chk(pcnt[0] == 8, "R3 first pulse intact", pcnt[0], 8);
        chk(pcnt[3] == 0, "R3 second command ignored", pcnt[3], 0);
        clr_cnt();
        issue(4'b0011);
        repeat (12) step();
        chk(pcnt[3] == 8, "R3 accepted after pulse", pcnt[3], 8);

        // R8: ready sequence
        dev_rdy = 1'b1; step();
        chk(!rdy_ff, "R8 single true", rdy_ff, 0);
        dev_rdy = 1'b0; step();
        chk(!rdy_ff, "R8 true-false", rdy_ff, 0);
        dev_rdy = 1'b1; step();
        chk(rdy_ff, "R8 true-false-true sets", rdy_ff, 1);

        // R7: keep / clear variants
        issue(4'b1100);
        chk(rdy_ff, "R7 11xx keeps ready", rdy_ff, 1);
        issue(4'b1000);
        chk(!rdy_ff, "R7 10xx clears ready", rdy_ff, 0);
        sw_ack = 1'b1; step(); sw_ack = 1'b0;
        chk(rdy_ff, "R8 sw_ack sets", rdy_ff, 1);
        sw_ack = 1'b1; issue(4'b1000); sw_ack = 1'b0;
        chk(!rdy_ff, "R8 clear wins over ack", rdy_ff, 0);

        // R4: reserved codes
        sw_ack = 1'b1; step(); sw_ack = 1'b0;
        step(); step();
        clr_cnt();
        for (int c = 4; c < 8; c++) issue(4'(c));
        repeat (12) step();
        chk(pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] == 0, "R4 no pulse", pcnt[0] + pcnt[3], 0);
        chk(out_mode == 2'b00, "R4 mode unchanged", out_mode, 0);
        chk(!out_valid, "R4 no queue entry", out_valid, 0);
        chk(rdy_ff, "R4 ready unchanged", rdy_ff, 1);

        // R5/R6/R11: mode travels with data
        out_take = 1'b0;
        put_data(8'hA1, 1); put_data(8'hB2, 1);
        issue(4'b1101);
        put_data(8'hC3, 1);
        step(); step(); step();
        chk(out_mode == 2'b00, "R5 mode held behind data", out_mode, 0);
        chk(out_valid && out_data == 8'hA1, "R11 head byte", out_data, 8'hA1);
        out_take = 1'b1;
        repeat (10) step();
        chk(exp_q.size() == 0, "R6 mode entry needs no take", exp_q.size(), 0);
        chk(out_mode == 2'b01, "R5 plot mode applied", out_mode, 1);
        issue(4'b1110); put_data(8'hD4, 1);
        issue(4'b1111); put_data(8'hE5, 1);
        repeat (8) step();
        chk(out_mode == 2'b11 && exp_q.size() == 0, "R5 spp modes", out_mode, 3);

        // R9: full queue
        out_take = 1'b0;
        for (int i = 0; i < 8; i++) put_data(8'(8'h10 + i), 1);
        chk(q_full, "R9 full flag", q_full, 1);
        put_data(8'hEE, 0);
        out_take = 1'b1;
        repeat (12) step();
        chk(exp_q.size() == 0 && !out_valid, "R9 overflow dropped", exp_q.size(), 0);
        out_take = 1'b0;
        data_wr = 1'b1; data_in = 8'h55;
        issue(4'b1100);
        data_wr = 1'b0;
        put_data(8'h66, 1);
        out_take = 1'b1;
        repeat (8) step();
        chk(exp_q.size() == 0 && out_mode == 2'b00, "R9 concurrent data dropped", exp_q.size(), 0);

        // R10: master clear
        issue(4'b1101);
        repeat (3) step();
        sw_ack = 1'b1; step(); sw_ack = 1'b0;
        out_take = 1'b0;
        put_data(8'h77, 0); put_data(8'h88, 0);
        issue(4'b0001);
        mclr = 1'b1; step(); mclr = 1'b0;
        chk(!out_valid, "R10 queue flushed", out_valid, 0);
        chk(out_mode == 2'b01, "R10 mode kept", out_mode, 1);
        chk(!rdy_ff, "R10 ready cleared", rdy_ff, 0);
        chk(pulse_o == 0, "R10 pulse stopped", pulse_o, 0);
        out_take = 1'b1;
        repeat (4) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule